// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two N-bit integers over N clock cycles. It uses one adder and one 2N-bit working register. When an operation starts, the upper half of the working register is cleared and the multiplier is loaded into the lower half. In every step the bit that has reached position zero decides whether the captured multiplicand is added into the upper half. The whole register then moves right by one place. Each step therefore uses up one multiplier bit, so no separate multiplier register is needed.

The adder is N+1 bits wide. Its top bit becomes the new most significant bit of the register after the shift, so no carry is lost in unsigned mode. In two's-complement mode the upper half and the multiplicand are sign-extended. The last step subtracts the multiplicand, because that step handles the multiplier's sign bit. A caller pulses `start` together with the operands and the mode, then waits for the one-cycle `done` pulse. The product output then holds its value until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself: after that edge `busy` is 0, `done` is 0 and `product` is 0.
- R2: When `start` is high and `busy` is low at a clock edge, the operation is accepted, and `busy` reads 1 after that edge.
- R3: `done` rises exactly N clock edges after the accepting edge and stays high for exactly one cycle. `busy` falls on the same edge that raises `done`.
- R4: With `signed_mode` = 0, `product` at `done` equals the unsigned product of `mcand` and `mplier` in all 2N bits, including the largest operands (N = 4: 15 x 15 gives 8'hE1, and 9 x 5 gives 8'h2D).
- R5: With `signed_mode` = 1, both operands are two's-complement and `product` at `done` is their 2N-bit two's-complement product (N = 4: 4'b1001 x 4'b0101 gives 8'hDD, and 4'b1000 x 4'b1000 gives 8'h40).
- R6: A `start` pulse while `busy` is high has no effect. The result and the timing of `done` are those of the operation already running.
- R7: Once `done` has been raised, `product` keeps its value on every following cycle until another start is accepted.
- R8: The operands and the mode are captured at the accepting edge. Changing `mcand`, `mplier` or `signed_mode` while `busy` is high does not change the result.
- R9: A zero operand in either position and in either mode gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation; ignored while busy |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier |
| busy | output | 1 | High while the iterations are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | 2N-bit result register |

## Verification
An accepted start shows up as `busy` one edge later. The product and the `done` pulse are due N edges after the accepting edge. The bench drives its inputs on falling edges and counts falling edges from the request. It expects `done` low for the first N samples, high on sample N+1 and low again on sample N+2. The product is read on the sample where `done` is high and compared again two samples later to check that it holds. Starts and operand changes made mid-run are placed inside that window, and the result at the normal `done` sample shows whether they leaked in.

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]   mcand_q;
  logic           sgn_q;
  logic [2*N-1:0] prod_q;
  logic [CW-1:0]  iter_q;

  logic       last_iter;
  logic [N:0] hi_ext, mc_ext, addend, partial;

  assign last_iter = (iter_q == CW'(N - 1));
  assign hi_ext    = {sgn_q & prod_q[2*N-1], prod_q[2*N-1:N]};
  assign mc_ext    = {sgn_q & mcand_q[N-1], mcand_q};
  assign addend    = prod_q[0] ? mc_ext : '0;
  assign partial   = (sgn_q && last_iter) ? hi_ext - addend : hi_ext + addend;
  assign product   = prod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      prod_q  <= '0;
      mcand_q <= '0;
      sgn_q   <= 1'b0;
      iter_q  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        prod_q <= {partial, prod_q[N-1:1]};
        iter_q <= iter_q + 1'b1;
        if (last_iter) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy    <= 1'b1;
        prod_q  <= {{N{1'b0}}, mplier};
        mcand_q <= mcand;
        sgn_q   <= signed_mode;
        iter_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           signed_mode,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  int unsigned    run_len;
  logic [2*N-1:0] want;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= 0;
      want    <= '0;
    end else begin
      run_len <= busy ? run_len + 1 : 0;
      if (start && !busy) begin
        if (signed_mode)
          want <= (2*N)'($signed({{N{mcand[N-1]}}, mcand}) * $signed({{N{mplier[N-1]}}, mplier}));
        else
          want <= (2*N)'({{N{1'b0}}, mcand} * {{N{1'b0}}, mplier});
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_done_len_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == N && !busy));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));
  p_result_r4_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == want));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
  .mcand(mcand), .mplier(mplier), .busy(busy), .done(done), .product(product)
);

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;
  localparam int N = 4;
  localparam int NV = 13;
  // {signed, mcand, mplier, expected}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'h9, 4'h5, 8'h2D},
    {1'b0, 4'hF, 4'hF, 8'hE1},
    {1'b0, 4'h0, 4'hD, 8'h00},
    {1'b0, 4'h7, 4'h1, 8'h07},
    {1'b0, 4'hC, 4'hA, 8'h78},
    {1'b0, 4'h1, 4'hF, 8'h0F},
    {1'b1, 4'h9, 4'h5, 8'hDD},
    {1'b1, 4'h8, 4'h8, 8'h40},
    {1'b1, 4'h7, 4'hF, 8'hF9},
    {1'b1, 4'hF, 4'hF, 8'h01},
    {1'b1, 4'h3, 4'h6, 8'h12},
    {1'b1, 4'h8, 4'h7, 8'hC8},
    {1'b1, 4'h5, 4'h0, 8'h00}
  };

  logic clk = 0, rst = 1, start = 0, signed_mode = 0;
  logic [N-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*N-1:0] product;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  shiftadd_mul #(.N(N)) u_shiftadd_mul (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .mcand(mcand), .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Start request at a falling edge; optional interference inside the run.
  task automatic run_op(input logic s, input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic [2*N-1:0] exp, input string req, input int disturb);
    start = 1; signed_mode = s; mcand = a; mplier = b;
    @(negedge clk);
    start = 0;
    chk("R2 busy", busy, 1);
    for (int i = 1; i <= N; i++) begin
      if (i > 1) chk("R3 done early", done, 0);
      if (disturb == 1 && i == 2) begin start = 1; mcand = ~a; mplier = ~b; end
      if (disturb == 2 && i == 2) begin signed_mode = ~s; mcand = a + 1'b1; mplier = b ^ 4'h6; end
      @(negedge clk);
      start = 0;
    end
    chk("R3 done", done, 1);
    chk("R3 busy low", busy, 0);
    chk(req, product, exp);
    @(negedge clk);
    chk("R3 one cycle", done, 0);
    @(negedge clk);
    chk("R7 hold", product, exp);
  endtask

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog: actual %0d expected <20000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 product", product, 0);
    rst = 0;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      logic [2*N-1:0] ref_p;
      ref_p = VEC[v][16] ? (2*N)'($signed({{N{VEC[v][15]}}, VEC[v][15:12]}) *
                                   $signed({{N{VEC[v][11]}}, VEC[v][11:8]}))
                         : (2*N)'(VEC[v][15:12] * VEC[v][11:8]);
      chk("table self", ref_p, VEC[v][7:0]);
      run_op(VEC[v][16], VEC[v][15:12], VEC[v][11:8], VEC[v][7:0],
             VEC[v][16] ? "R5 signed" : "R4 unsigned", 0);
    end
    run_op(0, 4'h0, 4'h0, 8'h00, "R9 zero", 0);
    run_op(1, 4'h0, 4'h9, 8'h00, "R9 zero", 0);
    run_op(0, 4'hB, 4'h3, 8'h21, "R6 start ignored", 1);
    run_op(1, 4'hA, 4'h3, 8'hEE, "R8 operands captured", 2);
    repeat (3) @(negedge clk);
    chk("R7 idle hold", product, 8'hEE);
    rst = 1; @(negedge clk); rst = 0;
    chk("R1 reset again", product, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule